// File: doc/BRIEF.md
# Block Ring Buffer with Overrun Detection

This block sits between a producer of 32-bit sample words and a slower consumer. Incoming words go into a circular memory. The memory is split into a power-of-two count of equal, power-of-two-sized blocks. Words land in order inside the block under the write index. When the last word of a block is accepted, a one-cycle completion pulse reports the number of that block. The write index then moves on, wrapping from the last block back to block 0. The consumer can drain finished blocks through a registered read port while the producer fills later ones. When the consumer is done with a block it frees it with a single-cycle release strobe.

The block keeps the read head, which is the oldest unreleased block, and a count of finished, unreleased blocks. An overrun happens when a block is finished and the next block to write is the read head, so every other block still holds unread data. An overrun is always counted and latched in a sticky flag. A policy input then chooses what happens next. In overwrite mode the oldest block is given up and the read head moves past it. In stop mode capture halts for good, until reset.

Control is a two-state machine. `ST_RUN` accepts words. `ST_HALT` refuses them. The transition `RUN→RUN` covers ordinary writes and overruns under the overwrite policy. The transition `RUN→HALT` is taken on an overrun under the stop policy. `HALT→HALT` holds until reset, and reset always returns the machine to `ST_RUN`.

Top module: `blk_ring`

## Requirements
- R1: After reset, `wr_ready`=1, `blk_done`=0, `rd_head`=0, `blk_avail`=0, `ovr_count`=0, `ovr_flag`=0 and `stopped`=0.
- R2: Accepted words (`wr_valid` && `wr_ready` at a clock edge) are stored in order. Word n of block b sits at word address b*BLK_WORDS+n. Writing starts at block 0, word 0.
- R3: The cycle after the last word of a block is accepted, `blk_done` is high for exactly one cycle, `blk_idx` holds that block's number and `blk_avail` has grown by one. Block NUM_BLKS-1 is followed by block 0.
- R4: `rd_data` shows the word stored at address `rd_blk`*BLK_WORDS+`rd_off` one cycle after that address is applied.
- R5: A `rel` pulse while `blk_avail`>0 advances `rd_head` by one (modulo NUM_BLKS) and lowers `blk_avail` by one.
- R6: A `rel` pulse while `blk_avail`=0 is ignored: `rd_head` and `blk_avail` are unchanged.
- R7: An overrun is a block completion that leaves all NUM_BLKS-1 other blocks unreleased. Each overrun increments `ovr_count` (saturating) in the same cycle as the `blk_done` pulse and sets `ovr_flag`, which stays set until reset.
- R8: With `policy_ovr`=1 at an overrun, `rd_head` advances by one and `blk_avail` stays at NUM_BLKS-1. Capture continues into the block that was oldest, replacing its contents.
- R9: With `policy_ovr`=0 at an overrun, the machine enters `ST_HALT`: `stopped`=1 and `wr_ready`=0 from the next cycle until reset, and `blk_avail`=NUM_BLKS. Further words are not accepted. Releases still free blocks but do not restart capture.
- R10: A release in the same cycle as a block completion is applied first. It prevents an overrun if it leaves a block free, and `blk_avail` is then unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_ovr | input | 1 | Overrun policy: 1 overwrite oldest, 0 stop capture |
| wr_valid | input | 1 | Producer word valid |
| wr_data | input | WORD_W | Producer word |
| wr_ready | output | 1 | Capture running, word accepted when valid |
| blk_done | output | 1 | One-cycle block completion pulse |
| blk_idx | output | $clog2(NUM_BLKS) | Number of the block just completed |
| rd_blk | input | $clog2(NUM_BLKS) | Read port block number |
| rd_off | input | $clog2(BLK_WORDS) | Read port word offset in block |
| rd_data | output | WORD_W | Registered read data |
| rel | input | 1 | Release strobe for the block at the read head |
| rd_head | output | $clog2(NUM_BLKS) | Oldest unreleased block |
| blk_avail | output | $clog2(NUM_BLKS)+1 | Completed, unreleased block count |
| ovr_count | output | CNT_W | Saturating overrun counter |
| ovr_flag | output | 1 | Sticky overrun flag |
| stopped | output | 1 | Capture halted by stop policy |

## Verification
Every result of a write or release is registered once. The completion pulse, block number, head, fill count, overrun counter, flag and stop state therefore change at the clock edge that accepts the stimulus. They are valid for the whole following cycle. Read data arrives one edge after the read address. The bench drives inputs on the falling edge and checks state on the next falling edge, half a cycle after the edge that updates it. A scoreboard queue receives a block number when the driver itself counts a finished block, and the monitor compares it against each `blk_done` pulse on falling edges. A pulse that nobody expected, or one that never arrives, is an error.

// File: rtl/ring_pkg.sv
`timescale 1ns/1ps
package ring_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } ring_state_t;
endpackage

// File: rtl/ring_mem.sv
`timescale 1ns/1ps
module ring_mem #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
        rd_data <= store[rd_addr];
    end
endmodule

// File: rtl/ovr_tally.sv
`timescale 1ns/1ps
module ovr_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            flag  <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
            if (count != '1) begin
                count <= count + CNT_W'(1);
            end
        end
    end

    // R7: the counter moves only on an overrun
    a_r7_count_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> $past(hit));
    // R7: the flag never clears without reset
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag);
endmodule

// File: rtl/ring_ctrl.sv
`timescale 1ns/1ps
module ring_ctrl
    import ring_pkg::*;
#(
    parameter int NUM_BLKS  = 4,
    parameter int BLK_WORDS = 8,
    localparam int BI_W     = $clog2(NUM_BLKS),
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int CW       = BI_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             policy_ovr,
    input  logic             wr_valid,
    input  logic             rel,
    output logic             wr_ready,
    output logic             wr_en,
    output logic [BI_W-1:0]  wr_blk,
    output logic [OFF_W-1:0] wr_off,
    output logic             blk_done,
    output logic [BI_W-1:0]  blk_idx,
    output logic [BI_W-1:0]  rd_head,
    output logic [CW-1:0]    blk_avail,
    output logic             ovr_hit,
    output logic             stopped
);
    localparam logic [CW-1:0]    LAST_FREE = CW'(NUM_BLKS - 1);
    localparam logic [OFF_W-1:0] LAST_OFF  = OFF_W'(BLK_WORDS - 1);

    ring_state_t state, state_nx;

    logic          blk_end;
    logic          rel_ok;
    logic          drop_old;
    logic [CW-1:0] avail_less;

    always_comb begin
        wr_ready = 1'b0;
        stopped  = 1'b0;
        unique case (state)
            ST_RUN:  wr_ready = 1'b1;
            ST_HALT: stopped  = 1'b1;
            default: stopped  = 1'b1;
        endcase
    end

    assign wr_en      = wr_valid && wr_ready;
    assign blk_end    = wr_en && (wr_off == LAST_OFF);
    assign rel_ok     = rel && (blk_avail != '0);
    assign avail_less = blk_avail - CW'(rel_ok);
    assign ovr_hit    = blk_end && (avail_less == LAST_FREE);
    assign drop_old   = ovr_hit && policy_ovr;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (ovr_hit && !policy_ovr) state_nx = ST_HALT;
            ST_HALT: state_nx = ST_HALT;
            default: state_nx = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_blk    <= '0;
            wr_off    <= '0;
            rd_head   <= '0;
            blk_avail <= '0;
            blk_done  <= 1'b0;
            blk_idx   <= '0;
        end else begin
            if (wr_en) begin
                wr_off <= wr_off + OFF_W'(1);
            end
            if (blk_end) begin
                wr_blk <= wr_blk + BI_W'(1);
            end
            if (rel_ok || drop_old) begin
                rd_head <= rd_head + BI_W'(1);
            end
            blk_avail <= avail_less + CW'(blk_end) - CW'(drop_old);
            blk_done  <= blk_end;
            blk_idx   <= wr_blk;
        end
    end

    // R9: no word is written once halted
    a_r9_halt_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !wr_en);
    // R9: halt is sticky until reset
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> stopped);
    // R3: a completion pulse always follows an accepted word
    a_r3_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> $past(wr_en));
    // R3: completion pulses last one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);
    // R8: fill level never exceeds the block count
    a_r8_avail_bound: assert property (@(posedge clk) disable iff (!rst_n)
        blk_avail <= CW'(NUM_BLKS));
    // R6: an empty-ring release leaves the head alone
    a_r6_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && blk_avail == '0 && !wr_en) |=> $stable(rd_head));
endmodule

// File: rtl/blk_ring.sv
`timescale 1ns/1ps
module blk_ring #(
    parameter int WORD_W    = 32,
    parameter int NUM_BLKS  = 4,
    parameter int BLK_WORDS = 8,
    parameter int CNT_W     = 8,
    localparam int BI_W     = $clog2(NUM_BLKS),
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int DEPTH    = NUM_BLKS * BLK_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              policy_ovr,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              blk_done,
    output logic [BI_W-1:0]   blk_idx,
    input  logic [BI_W-1:0]   rd_blk,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [WORD_W-1:0] rd_data,
    input  logic              rel,
    output logic [BI_W-1:0]   rd_head,
    output logic [BI_W:0]     blk_avail,
    output logic [CNT_W-1:0]  ovr_count,
    output logic              ovr_flag,
    output logic              stopped
);
    logic             wr_en;
    logic [BI_W-1:0]  wr_blk;
    logic [OFF_W-1:0] wr_off;
    logic             ovr_hit;

    ring_ctrl #(.NUM_BLKS(NUM_BLKS), .BLK_WORDS(BLK_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .policy_ovr(policy_ovr),
        .wr_valid(wr_valid), .rel(rel), .wr_ready(wr_ready),
        .wr_en(wr_en), .wr_blk(wr_blk), .wr_off(wr_off),
        .blk_done(blk_done), .blk_idx(blk_idx), .rd_head(rd_head),
        .blk_avail(blk_avail), .ovr_hit(ovr_hit), .stopped(stopped)
    );

    ring_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_addr({wr_blk, wr_off}),
        .wr_data(wr_data), .rd_addr({rd_blk, rd_off}), .rd_data(rd_data)
    );

    ovr_tally #(.CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .hit(ovr_hit),
        .count(ovr_count), .flag(ovr_flag)
    );
endmodule

// File: tb/tb_blk_ring.sv
`timescale 1ns/1ps
module tb_blk_ring;
    localparam int NB = 4;
    localparam int BW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        policy_ovr = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        blk_done;
    logic [1:0]  blk_idx;
    logic [1:0]  rd_blk = '0;
    logic [2:0]  rd_off = '0;
    logic [31:0] rd_data;
    logic        rel = 1'b0;
    logic [1:0]  rd_head;
    logic [2:0]  blk_avail;
    logic [7:0]  ovr_count;
    logic        ovr_flag;
    logic        stopped;

    int checks = 0;
    int errors = 0;
    int m_wb = 0;
    int m_wo = 0;
    logic [31:0] exp_mem [NB*BW];
    int exp_q [$];

    always #2 clk = ~clk;

    blk_ring dut (
        .clk(clk), .rst_n(rst_n), .policy_ovr(policy_ovr),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .blk_done(blk_done), .blk_idx(blk_idx), .rd_blk(rd_blk),
        .rd_off(rd_off), .rd_data(rd_data), .rel(rel), .rd_head(rd_head),
        .blk_avail(blk_avail), .ovr_count(ovr_count), .ovr_flag(ovr_flag),
        .stopped(stopped)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: scoreboard for completion pulses (R3)
    always @(negedge clk) begin
        if (rst_n && blk_done) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected blk_done", 1, 0);
            end else begin
                chk("R3 blk_idx", blk_idx, exp_q.pop_front());
            end
        end
    end

    // Driver: one word, optional release in the same cycle
    task automatic put_word(input logic [31:0] d, input logic r);
        logic acc;
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        rel      = r;
        acc      = wr_ready;
        @(posedge clk);
        if (acc) begin
            exp_mem[m_wb*BW + m_wo] = d;
            m_wo++;
            if (m_wo == BW) begin
                m_wo = 0;
                exp_q.push_back(m_wb);
                m_wb = (m_wb + 1) % NB;
            end
        end
        @(negedge clk);
        wr_valid = 1'b0;
        rel      = 1'b0;
    endtask

    task automatic put_block(input logic [31:0] base);
        for (int i = 0; i < BW; i++) put_word(base + 32'(i), 1'b0);
    endtask

    task automatic pulse_rel();
        @(negedge clk);
        rel = 1'b1;
        @(negedge clk);
        rel = 1'b0;
    endtask

    task automatic read_chk(input string tag, input int b, input int o);
        @(negedge clk);
        rd_blk = 2'(b);
        rd_off = 3'(o);
        @(negedge clk);
        chk(tag, rd_data, exp_mem[b*BW + o]);
    endtask

    task automatic state_chk(input string tag, input int head, input int avail,
                             input int cnt, input int flag, input int stp);
        chk({tag, " rd_head"}, rd_head, head);
        chk({tag, " blk_avail"}, blk_avail, avail);
        chk({tag, " ovr_count"}, ovr_count, cnt);
        chk({tag, " ovr_flag"}, ovr_flag, flag);
        chk({tag, " stopped"}, stopped, stp);
        chk({tag, " wr_ready"}, wr_ready, stp ? 0 : 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_wb = 0;
        m_wo = 0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        state_chk("R1", 0, 0, 0, 0, 0);
        chk("R1 blk_done", blk_done, 0);

        // R2 R3: two blocks, pulses 0 and 1
        put_block(32'hA000_0000);
        put_block(32'hA100_0000);
        state_chk("R3 two blocks", 0, 2, 0, 0, 0);

        // R4 R2: read back block 0 and one word of block 1
        for (int i = 0; i < BW; i++) read_chk("R4 R2 blk0", 0, i);
        read_chk("R4 R2 blk1", 1, 5);

        // R5 release twice, R6 release on empty ring
        pulse_rel();
        state_chk("R5 rel1", 1, 1, 0, 0, 0);
        pulse_rel();
        state_chk("R5 rel2", 2, 0, 0, 0, 0);
        pulse_rel();
        state_chk("R6 empty rel", 2, 0, 0, 0, 0);

        // R3 wrap: blocks 2,3,0
        put_block(32'hB200_0000);
        put_block(32'hB300_0000);
        put_block(32'hB000_0000);
        state_chk("R3 wrap", 2, 3, 0, 0, 0);

        // R7 R8: block 1 completes with all others held -> overwrite
        put_block(32'hB100_0000);
        state_chk("R7 R8 ovr1", 3, 3, 1, 1, 0);
        read_chk("R8 head data", 3, 2);

        // R8: block 2 overwritten with new data
        put_block(32'hC200_0000);
        state_chk("R8 ovr2", 0, 3, 2, 1, 0);
        read_chk("R8 replaced data", 2, 0);
        chk("R8 new word", rd_data, 32'hC200_0000);

        // R10: release together with completion of block 3
        for (int i = 0; i < BW - 1; i++) put_word(32'hD300_0000 + 32'(i), 1'b0);
        put_word(32'hD300_0007, 1'b1);
        state_chk("R10 rel+done", 1, 3, 2, 1, 0);

        // R9: stop policy
        policy_ovr = 1'b0;
        do_reset();
        state_chk("R1 second reset", 0, 0, 0, 0, 0);
        put_block(32'hE000_0000);
        put_block(32'hE100_0000);
        put_block(32'hE200_0000);
        state_chk("R9 pre", 0, 3, 0, 0, 0);
        put_block(32'hE300_0000);
        state_chk("R9 halted", 0, 4, 1, 1, 1);
        put_word(32'hFFFF_FFFF, 1'b0);
        repeat (2) @(negedge clk);
        state_chk("R9 refused", 0, 4, 1, 1, 1);
        read_chk("R9 blk0 intact", 0, 0);
        pulse_rel();
        state_chk("R9 rel no restart", 1, 3, 1, 1, 1);

        repeat (3) @(negedge clk);
        chk("R3 queue drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule